// File: doc/BRIEF.md
# Add/Subtract Condition Flag Unit

This block sits beside an integer adder in a datapath and produces, in the same cycle as the operands, the sum or difference of two operands together with six condition flags: negative, zero, signed overflow, carry/borrow, a nibble carry (out of bit 3) and even parity of the low byte. The operation width is chosen per operation from a family of sizes: 8, 16 and 32 bits with the default parameters. A carry-in feeds both addition and subtraction. For subtraction it acts as a borrow-in, so that chains of wider values can be built.

The result is combinational. The six flags are captured into a status register on a rising clock edge only when the update enable is high. When the enable is low, the register keeps its last contents. Narrow operations zero-extend their result to the full output width, so the upper bits never carry stale data.

Top module: `alu_flag_unit`

## Requirements
- R1: `result` equals `op_a + op_b + carry_in` (when `sub_sel`=0) or `op_a - op_b - carry_in` (when `sub_sel`=1), truncated to the selected width and zero-extended above it. The `size_sel` encoding is 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and 3 = 32 bits.
- R2: `flag_n` is the most significant bit of the result at the selected width.
- R3: `flag_z` is 1 exactly when the result at the selected width is all zeros.
- R4: `flag_v` is 1 when the operation overflows as a signed two's-complement operation at the selected width.
- R5: `flag_c` is the carry out of the top bit of the selected width for addition. For subtraction it is 1 when a borrow occurs, meaning the unsigned value of `op_a` is less than `op_b + carry_in`.
- R6: `flag_a` is the carry from bit 3 into bit 4 for addition. For subtraction it is 1 when bit 3 borrows from bit 4, meaning `op_a[3:0] < op_b[3:0] + carry_in`.
- R7: `flag_p` is 1 when `result[7:0]` holds an even number of ones, whatever the width.
- R8: The flags change only at a rising clock edge where `flag_we` is 1, and then show the values from that cycle's operands. When `flag_we` is 0, they hold their previous values.
- R9: While `rst_n` is low, all six flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low asynchronous reset of the flags |
| op_a | input | 32 | First operand (minuend for subtraction) |
| op_b | input | 32 | Second operand (subtrahend for subtraction) |
| carry_in | input | 1 | Carry-in for addition, borrow-in for subtraction |
| sub_sel | input | 1 | 0 selects addition, 1 selects subtraction |
| size_sel | input | 2 | Operation width: 0 = 8, 1 = 16, 2 and 3 = 32 bits |
| flag_we | input | 1 | Enables the flag update at the next rising edge |
| result | output | 32 | Sum or difference, zero-extended above the width |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered signed overflow flag |
| flag_c | output | 1 | Registered carry/borrow flag |
| flag_a | output | 1 | Registered nibble carry/borrow flag |
| flag_p | output | 1 | Registered low-byte even parity flag |

## Verification
`result` depends only on the current inputs, with no register in its path. The bench therefore drives the operands on a falling edge and checks `result` a short settle delay later, in the same cycle. The flags pass through one register. They are due at the first rising edge after the operands are applied with `flag_we` high, so the bench checks them on the falling edge that follows that rising edge. When `flag_we` is low, the bench checks at that same point that the flags still match the last committed values, while `result` shows the new operation.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
      logic a;
      logic p;
   } cond_flags_t;

   localparam cond_flags_t FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0, a: 1'b0, p: 1'b0};

endpackage

// File: rtl/alu_flag_adder.sv
module alu_flag_adder #(
   parameter int BASE_W    = 8,
   parameter int NUM_SIZES = 3,
   parameter int MAX_W     = BASE_W << (NUM_SIZES - 1)
) (
   input  logic [MAX_W-1:0] a_in,
   input  logic [MAX_W-1:0] b_in,
   input  logic             cin,
   input  logic             sub,
   input  logic [1:0]       sel,
   output logic [MAX_W-1:0] sum_out,
   output logic             top_carry,
   output logic             ovf,
   output logic             nib_carry,
   output logic [1:0]       pick
);

   logic [MAX_W-1:0] b_eff;
   logic             c_eff;
   logic [MAX_W-1:0] slice_sum [NUM_SIZES];
   logic             slice_co  [NUM_SIZES];
   logic             slice_ov  [NUM_SIZES];

   // subtraction as a + ~b + ~borrow_in
   assign b_eff = sub ? ~b_in : b_in;
   assign c_eff = cin ^ sub;

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      localparam int W = BASE_W << k;
      logic [W:0] s;
      assign s = {1'b0, a_in[W-1:0]} + {1'b0, b_eff[W-1:0]} + {{W{1'b0}}, c_eff};
      if (W == MAX_W) begin : g_full
         assign slice_sum[k] = s[W-1:0];
      end else begin : g_ext
         assign slice_sum[k] = {{(MAX_W-W){1'b0}}, s[W-1:0]};
      end
      assign slice_co[k] = s[W];
      assign slice_ov[k] = (a_in[W-1] == b_eff[W-1]) && (s[W-1] != a_in[W-1]);
   end

   assign pick      = (int'(sel) >= NUM_SIZES) ? 2'(NUM_SIZES - 1) : sel;
   assign sum_out   = slice_sum[pick];
   assign top_carry = slice_co[pick];
   assign ovf       = slice_ov[pick];
   // carry into bit 4 recovered from the smallest slice
   assign nib_carry = a_in[4] ^ b_eff[4] ^ slice_sum[0][4];

endmodule

// File: rtl/alu_flag_eval.sv
module alu_flag_eval
   import alu_flag_pkg::*;
#(
   parameter int BASE_W    = 8,
   parameter int NUM_SIZES = 3,
   parameter int MAX_W     = BASE_W << (NUM_SIZES - 1)
) (
   input  logic [MAX_W-1:0] sum_in,
   input  logic [1:0]       pick,
   input  logic             sub,
   input  logic             top_carry,
   input  logic             ovf,
   input  logic             nib_carry,
   output cond_flags_t      flags
);

   int msb_idx;

   always_comb begin
      msb_idx = (BASE_W << pick) - 1;
      flags.n = sum_in[msb_idx];
      flags.z = (sum_in == '0);
      flags.v = ovf;
      flags.c = top_carry ^ sub;
      flags.a = nib_carry ^ sub;
      flags.p = ~^sum_in[7:0];
   end

endmodule

// File: rtl/alu_flag_status.sv
module alu_flag_status
   import alu_flag_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  cond_flags_t d,
   output cond_flags_t q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= FLAGS_CLEAR;
      else if (we) q <= d;
   end

   // R8
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));

   // R8
   flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(d)));

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int BASE_W    = 8,
   parameter int NUM_SIZES = 3,
   parameter int MAX_W     = BASE_W << (NUM_SIZES - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MAX_W-1:0] op_a,
   input  logic [MAX_W-1:0] op_b,
   input  logic             carry_in,
   input  logic             sub_sel,
   input  logic [1:0]       size_sel,
   input  logic             flag_we,
   output logic [MAX_W-1:0] result,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_v,
   output logic             flag_c,
   output logic             flag_a,
   output logic             flag_p
);

   if (BASE_W < 8) begin : g_bad_base
      $error("BASE_W must be at least 8 for nibble carry and byte parity");
   end
   if (NUM_SIZES < 1 || NUM_SIZES > 4) begin : g_bad_sizes
      $error("NUM_SIZES must be 1 to 4 to fit the 2-bit size select");
   end
   if (MAX_W != (BASE_W << (NUM_SIZES - 1))) begin : g_bad_max
      $error("MAX_W must equal BASE_W << (NUM_SIZES-1)");
   end

   logic [MAX_W-1:0] sum_w;
   logic             co_w, ov_w, nib_w;
   logic [1:0]       pick_w;
   cond_flags_t      next_flags, cur_flags;

   alu_flag_adder #(.BASE_W(BASE_W), .NUM_SIZES(NUM_SIZES), .MAX_W(MAX_W)) u_add (
      .a_in(op_a), .b_in(op_b), .cin(carry_in), .sub(sub_sel), .sel(size_sel),
      .sum_out(sum_w), .top_carry(co_w), .ovf(ov_w), .nib_carry(nib_w), .pick(pick_w)
   );

   alu_flag_eval #(.BASE_W(BASE_W), .NUM_SIZES(NUM_SIZES), .MAX_W(MAX_W)) u_eval (
      .sum_in(sum_w), .pick(pick_w), .sub(sub_sel), .top_carry(co_w),
      .ovf(ov_w), .nib_carry(nib_w), .flags(next_flags)
   );

   alu_flag_status u_stat (
      .clk(clk), .rst_n(rst_n), .we(flag_we), .d(next_flags), .q(cur_flags)
   );

   assign result = sum_w;
   assign flag_n = cur_flags.n;
   assign flag_z = cur_flags.z;
   assign flag_v = cur_flags.v;
   assign flag_c = cur_flags.c;
   assign flag_a = cur_flags.a;
   assign flag_p = cur_flags.p;

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> !rst_n |-> ({flag_n, flag_z, flag_v, flag_c, flag_a, flag_p} == 6'b0));

   // R3
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> (flag_z == ($past(result) == '0)));

   // R7
   parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> (flag_p == ~^$past(result[7:0])));

   // R2
   neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && size_sel == 2'd0) |=> (flag_n == $past(result[BASE_W-1])));

   // R1
   narrow_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_sel == 2'd0) |-> (result[MAX_W-1:BASE_W] == '0));

endmodule

// File: tb/alu_flag_unit_test.sv
`timescale 1ns/1ps
module alu_flag_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic        carry_in = 1'b0, sub_sel = 1'b0, flag_we = 1'b0;
   logic [1:0]  size_sel = 2'd0;
   logic [31:0] result;
   logic        flag_n, flag_z, flag_v, flag_c, flag_a, flag_p;

   int tests = 0;
   int fails = 0;
   logic [5:0] model = 6'b0;   // {n,z,v,c,a,p}

   always #5 clk = ~clk;

   alu_flag_unit uut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
      .sub_sel(sub_sel), .size_sel(size_sel), .flag_we(flag_we), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
      .flag_a(flag_a), .flag_p(flag_p)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // drive one operation, check result now and flags after the next edge
   task automatic run_op(logic [31:0] a, logic [31:0] b, logic ci, logic sb,
                         logic [1:0] sel, logic we);
      int w;
      logic [63:0] m, am, bm, full, r;
      logic ea, en, ev, ec, sa, sbit, sr;
      w = (sel == 2'd0) ? 8 : (sel == 2'd1) ? 16 : 32;
      m = (64'd1 << w) - 64'd1;
      am = {32'd0, a} & m;
      bm = {32'd0, b} & m;
      full = sb ? (am - bm - {63'd0, ci}) : (am + bm + {63'd0, ci});
      r = full & m;
      ec = full[w];
      ea = sb ? ({1'b0, a[3:0]} < ({1'b0, b[3:0]} + {4'd0, ci}))
              : (({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, ci}) > 5'd15);
      sa = am[w-1]; sbit = bm[w-1]; sr = r[w-1];
      ev = sb ? (sa != sbit && sr != sa) : (sa == sbit && sr != sa);
      en = sr;
      @(negedge clk);
      op_a = a; op_b = b; carry_in = ci; sub_sel = sb; size_sel = sel; flag_we = we;
      #1;
      check("R1 result", result, r[31:0]);
      if (we) model = {en, (r == 64'd0), ev, ec, ea, ~^r[7:0]};
      @(posedge clk);
      @(negedge clk);
      flag_we = 1'b0;
      check("R2 flag_n", {31'd0, flag_n}, {31'd0, model[5]});
      check("R3 flag_z", {31'd0, flag_z}, {31'd0, model[4]});
      check("R4 flag_v", {31'd0, flag_v}, {31'd0, model[3]});
      check("R5 flag_c", {31'd0, flag_c}, {31'd0, model[2]});
      check("R6 flag_a", {31'd0, flag_a}, {31'd0, model[1]});
      check("R7 flag_p", {31'd0, flag_p}, {31'd0, model[0]});
   endtask

   task automatic test_reset();
      @(negedge clk);
      check("R9 flags in reset", {26'd0, flag_n, flag_z, flag_v, flag_c, flag_a, flag_p}, 32'd0);
   endtask

   task automatic test_add8();
      run_op(32'h0000_0012, 32'h0000_0034, 1'b0, 1'b0, 2'd0, 1'b1);
      run_op(32'h0000_00FF, 32'h0000_0001, 1'b0, 1'b0, 2'd0, 1'b1);   // R3 zero, R5 carry
      run_op(32'hABCD_1280, 32'h1111_0080, 1'b1, 1'b0, 2'd0, 1'b1);   // R1 upper ignored
   endtask

   task automatic test_sub();
      run_op(32'h0000_0005, 32'h0000_0007, 1'b0, 1'b1, 2'd0, 1'b1);   // R5 borrow
      run_op(32'h0000_1234, 32'h0000_1234, 1'b0, 1'b1, 2'd1, 1'b1);   // R3 zero
      run_op(32'h0000_0010, 32'h0000_000F, 1'b1, 1'b1, 2'd2, 1'b1);   // borrow-in
   endtask

   task automatic test_overflow();
      run_op(32'h0000_007F, 32'h0000_0001, 1'b0, 1'b0, 2'd0, 1'b1);   // R4 pos+pos
      run_op(32'h0000_8000, 32'h0000_0001, 1'b0, 1'b1, 2'd1, 1'b1);   // R4 neg-pos
      run_op(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 2'd2, 1'b1);   // R4 pos-neg
   endtask

   task automatic test_aux();
      run_op(32'h0000_0008, 32'h0000_0008, 1'b0, 1'b0, 2'd0, 1'b1);   // R6 add
      run_op(32'h0000_0007, 32'h0000_0008, 1'b1, 1'b0, 2'd1, 1'b1);   // R6 cin into nibble
      run_op(32'h0000_0010, 32'h0000_0001, 1'b0, 1'b1, 2'd2, 1'b1);   // R6 sub borrow
   endtask

   task automatic test_parity();
      run_op(32'h0001_0000, 32'h0000_0003, 1'b0, 1'b0, 2'd2, 1'b1);   // R7 low byte only
      run_op(32'h0000_0000, 32'h0000_0007, 1'b0, 1'b0, 2'd1, 1'b1);   // R7 odd
   endtask

   task automatic test_sizes();
      run_op(32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'd1, 1'b1);   // 16-bit wrap
      run_op(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'd2, 1'b1);   // 32-bit wrap
      run_op(32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0, 2'd3, 1'b1);   // sel 3 = 32
   endtask

   task automatic test_hold();
      run_op(32'h0000_0080, 32'h0000_0080, 1'b0, 1'b0, 2'd0, 1'b1);
      run_op(32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 2'd0, 1'b0);   // R8 hold
      run_op(32'h0000_0005, 32'h0000_0007, 1'b0, 1'b1, 2'd2, 1'b0);   // R8 hold
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            test_reset();
            @(negedge clk);
            rst_n = 1'b1;
            test_add8();
            test_sub();
            test_overflow();
            test_aux();
            test_parity();
            test_sizes();
            test_hold();
         end
         begin
            repeat (5000) @(posedge clk);
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule